// File: doc/BRIEF.md
# Interrupt Control Register with Port-Change Detection

This block is the interrupt enable and status register of a small microcontroller core, together with the event logic that feeds it. Three sources raise flags. The first is a one-cycle timer-overflow pulse. The second is a rising edge on an external interrupt pin. The third is a change on the upper nibble of an 8-bit input port. Each flag sits next to its own enable. A global enable and a peripheral enable gate the single registered interrupt request line to the core.

The core reaches the register over a simple byte bus with read and write strobes. The register is mirrored in every bank, so it answers at offsets 0x0B, 0x8B, 0x10B and 0x18B. The port itself can be read at offset 0x06 in any bank. That read takes a fresh snapshot of pins 7 to 4, which is the reference the change detector compares against.

Software must read the port before a clear of the port-change flag can stick. While the pins differ from the snapshot, hardware keeps setting the flag again.

Top module: `intr_ctl_reg`

## Requirements
- R1: Bit layout of the register, bit 7 down to bit 0: global enable, peripheral enable, timer enable, external-pin enable, port-change enable, timer flag, external-pin flag, port-change flag. A write stores the byte and a read returns it.
- R2: The register is selected when the low 7 address bits equal 0x0B, so 0x0B, 0x8B, 0x10B and 0x18B all reach the same storage. A write to any other address leaves the register unchanged.
- R3: The timer flag (bit 2) sets on a timer-overflow pulse. The external-pin flag (bit 1) sets on a rising edge of the pin after a 2-flop synchronizer. Both set whatever the enable bits hold.
- R4: Hardware never clears a flag; only a software write of 0 does. If an event and a write of 0 to its flag fall in the same cycle, the flag ends up set.
- R5: The port-change flag (bit 0) is set in every cycle where synchronized pins 7 to 4 differ from the snapshot. A read at low address 0x06 returns the 8 synchronized port pins and loads the snapshot from pins 7 to 4. A change on pins 3 to 0 has no effect on the flag.
- R6: The request line is registered and equals bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND periph_irq)). With bit 7 at 0 it stays low.
- R7: The peripheral request input reaches the request line only while bit 6 is 1.
- R8: After reset, the register reads 0x00, the request line is low and the snapshot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 9 | Byte address, banks in the top two bits |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 8 | I/O port pins, asynchronous |
| periph_irq | input | 1 | Combined peripheral request |
| irq | output | 1 | Registered interrupt request to the core |

## Verification
The bench raises flags with every enable at 0. A design that gated flag setting with the enables would read back 0 there. It writes 0 in the same cycle as a timer pulse; a design where the write wins loses the event. It clears the port-change flag before and after a port read. A detector that does not re-assert during the mismatch, or whose snapshot does not refresh on the read, leaves the wrong flag value. It also writes through each mirror and reads through a different one, and it toggles the global and peripheral enables to show a request masked and then released.

// File: rtl/intr_ctl_reg.sv
module intr_ctl_reg #(
  parameter int          AW       = 9,
  parameter logic [6:0]  CTL_OFS  = 7'h0B,
  parameter logic [6:0]  PORT_OFS = 7'h06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          tmr_ovf,
  input  logic          ext_pin,
  input  logic [7:0]    port_pins,
  input  logic          periph_irq,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_MASK = AW'(7'h7F);

  logic [7:0] reg_q, reg_d, base;
  logic [7:0] port_s1, port_s2;
  logic [3:0] snap_q;
  logic       ext_s1, ext_s2, ext_s3;

  wire sel_ctl   = (bus_addr & OFS_MASK) == AW'(CTL_OFS);
  wire sel_port  = (bus_addr & OFS_MASK) == AW'(PORT_OFS);
  wire wr_ctl    = bus_wr & sel_ctl;
  wire rd_port   = bus_rd & sel_port;
  wire ext_rise  = ext_s2 & ~ext_s3;
  wire mismatch  = port_s2[7:4] != snap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {ext_s3, ext_s2, ext_s1} <= '0;
      port_s1 <= '0;
      port_s2 <= '0;
    end else begin
      {ext_s3, ext_s2, ext_s1} <= {ext_s2, ext_s1, ext_pin};
      port_s1 <= port_pins;
      port_s2 <= port_s1;
    end

  assign base  = wr_ctl ? bus_wdata : reg_q;
  assign reg_d = base | {5'b0, tmr_ovf, ext_rise, mismatch};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_q  <= '0;
      snap_q <= '0;
      irq    <= 1'b0;
    end else begin
      reg_q <= reg_d;
      if (rd_port) snap_q <= port_s2[7:4];
      irq <= reg_q[7] & ((reg_q[5] & reg_q[2]) | (reg_q[4] & reg_q[1]) |
                         (reg_q[3] & reg_q[0]) | (reg_q[6] & periph_irq));
    end

  assign bus_rdata = sel_ctl  ? reg_q :
                     sel_port ? port_s2 : 8'h00;

  p_wr_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> reg_q[7:3] == $past(bus_wdata[7:3]));

  p_tmr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_q[2]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> (reg_q[2:0] & $past(reg_q[2:0])) == $past(reg_q[2:0]));

  p_rb_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_s2[7:4] != snap_q) |=> reg_q[0]);

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q[7] |=> !irq);

  p_peie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[7:6] == 2'b10 && (reg_q[5:3] & reg_q[2:0]) == 3'b000) |=> !irq);
endmodule

// File: tb/intr_ctl_reg_tb.sv
module intr_ctl_reg_tb_top;
  logic       clk = 0, rst_n = 0;
  logic [8:0] bus_addr = '0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       tmr_ovf = 0, ext_pin = 0, periph_irq = 0, irq;
  logic [7:0] port_pins = '0;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  intr_ctl_reg dut_i (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .tmr_ovf, .ext_pin, .port_pins, .periph_irq, .irq);

  // {write addr, write data, read addr, expected byte, expected irq}
  localparam logic [34:0] VEC [7] = '{
    {9'h00B, 8'hA4, 9'h08B, 8'hA4, 1'b1},
    {9'h08B, 8'h24, 9'h10B, 8'h24, 1'b0},
    {9'h10B, 8'h92, 9'h18B, 8'h92, 1'b1},
    {9'h18B, 8'h89, 9'h00B, 8'h89, 1'b1},
    {9'h00B, 8'hC0, 9'h08B, 8'hC0, 1'b0},
    {9'h08B, 8'h00, 9'h18B, 8'h00, 1'b0},
    {9'h00C, 8'hFF, 9'h00B, 8'h00, 1'b0}
  };

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    rd(9'h00B, v); chk("R8 reset value", v, 8'h00);
    chk("R8 reset irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][34:26], VEC[i][25:18]);
      idle(1);
      rd(VEC[i][17:9], v);
      chk($sformatf("R1/R2 vector %0d readback", i), v, VEC[i][8:1]);
      chk($sformatf("R6 vector %0d irq", i), {7'b0, irq}, {7'b0, VEC[i][0]});
    end

    // R3 timer flag with all enables clear
    @(negedge clk); tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
    idle(2); rd(9'h10B, v); chk("R3 timer flag, enables off", v, 8'h04);
    chk("R6 no irq with enables off", {7'b0, irq}, 8'h00);
    wr(9'h00B, 8'h00); idle(3); rd(9'h00B, v); chk("R4 software clear", v, 8'h00);

    // R3 external pin edge
    @(negedge clk); ext_pin = 1; idle(5);
    rd(9'h00B, v); chk("R3 ext edge flag", v, 8'h02);
    wr(9'h00B, 8'h00); idle(4); rd(9'h00B, v); chk("R3 level holds no re-set", v, 8'h00);
    ext_pin = 0;

    // R4 event beats write of 0
    @(negedge clk); bus_addr = 9'h00B; bus_wdata = 8'h00; bus_wr = 1; tmr_ovf = 1;
    @(negedge clk); bus_wr = 0; tmr_ovf = 0;
    rd(9'h00B, v); chk("R4 event wins over clear", v, 8'h04);
    wr(9'h00B, 8'h00);

    // R5 port change
    @(negedge clk); port_pins = 8'h03; idle(5);
    rd(9'h00B, v); chk("R5 low pins ignored", v, 8'h00);
    port_pins = 8'h23; idle(5);
    rd(9'h00B, v); chk("R5 change flag set", v, 8'h01);
    wr(9'h00B, 8'h00); idle(2);
    rd(9'h08B, v); chk("R5 flag re-sets during mismatch", v, 8'h01);
    rd(9'h106, v); chk("R5 port read data", v, 8'h23);
    wr(9'h00B, 8'h00); idle(2);
    rd(9'h00B, v); chk("R5 clear holds after port read", v, 8'h00);

    // R6 global mask then release
    wr(9'h00B, 8'h24); idle(2); chk("R6 masked by global", {7'b0, irq}, 8'h00);
    wr(9'h00B, 8'hA4); idle(1); chk("R6 released by global", {7'b0, irq}, 8'h01);

    // R7 peripheral enable
    wr(9'h00B, 8'h80); periph_irq = 1; idle(2);
    chk("R7 periph blocked", {7'b0, irq}, 8'h00);
    wr(9'h00B, 8'hC0); idle(1); chk("R7 periph passes", {7'b0, irq}, 8'h01);
    periph_irq = 0; idle(2); chk("R7 periph drop", {7'b0, irq}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule